// File: doc/BRIEF.md
# Sector Transfer Sequencer

This block is a hardware master for the register port of a flash-card controller that also handles FPGA configuration. A requester asks for one of three tasks: read the card's identify sector, read sectors, or write sectors. It supplies a starting block address and a sector count, and pulses a start strobe. The sequencer then runs the whole register dialogue on its own. It wins the bus lock from the controller, polls until the card can take a command, and writes the address and the command word. It puts the configuration side into reset, then moves the data one 32-byte buffer at a time through the data port. When it has finished it pulses done, together with an error flag latched from the controller's error interrupt.

The device side is a plain register port. A one-cycle request either writes a 16-bit value or asks for a read whose data returns later with a valid strobe. Status is 32 bits wide, read as a low half and a high half. Read data leaves on a word stream, and write data is pulled word by word from the requester. Once the lock is won it is kept across operations until the requester drops its hold input. A read that is never answered is retried after a timeout, so one lost response cannot hang the sequencer.

Top module: `sect_seq`

## Requirements
- R1: While reset is held, and in the cycles after it with no start, `reg_req`, `req_done` and `req_busy` are all 0.
- R2: Lock acquisition reads status low (0x04). If bit 1 is already 1, no control write is made for the lock. Otherwise control (0x18) is read, written back with bit 1 set, and status low is polled until bit 1 reads 1. No command is written without the grant.
- R3: The command word (0x14) is written only after a status-low read shows bit 8 = 1 and a later status-high read (0x06, bit 1 = card busy, status bit 17) shows 0, with no failing read in between.
- R4: The command word has the opcode in bits 15:8 (identify 0x02, read 0x03, write 0x04) and the sector count in bits 7:0. The count field is 0 for identify.
- R5: For read and write, address bits 15:0 go to 0x10 and then {4'b0, address bits 27:16} to 0x12, before the command. Identify writes neither register.
- R6: After the command, control is read and written back with bit 7 set and every other bit unchanged.
- R7: Data moves in buffers of 16 word accesses at 0x40. Each buffer starts only after a status-low read with bit 5 = 1 and a following status-high read with bit 1 = 0. Identify moves 16 buffers; read and write move count × 16.
- R8: On a read or identify, each returned data word appears once on `rx_valid`/`rx_data`, in order. On a write, each data-port write carries `tx_data` and pulses `tx_pop` in that cycle.
- R9: A start with a task code of 1 (identify), 2 (read) or 3 (write) and, for read or write, a nonzero count sets `req_busy` from the next cycle. The operation ends with a one-cycle `req_done` and then returns to idle. A start while busy, with task code 0, or with a zero count for read or write is ignored.
- R10: An `irq_err` pulse during an operation makes `req_err` read 1 when `req_done` pulses. A new start clears it.
- R11: When idle, holding the lock, with `req_hold` low, the sequencer reads control and writes it back with bit 1 cleared. The next operation acquires the lock again.
- R12: A register read left unanswered is abandoned and issued again. The second request is sampled exactly TIMEOUT+1 cycles after the first.
- R13: At most one register read is outstanding. A new read is requested only after the previous one is answered or abandoned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_start | input | 1 | Start strobe for one operation |
| req_task | input | 2 | 1 identify, 2 read, 3 write |
| req_lba | input | 28 | Starting block address |
| req_count | input | CNT_W | Sector count for read and write |
| req_hold | input | 1 | Keep the bus lock while high |
| req_busy | output | 1 | Operation or lock release in progress |
| req_done | output | 1 | One-cycle end-of-operation pulse |
| req_err | output | 1 | Error seen during the operation, valid with done |
| rx_valid | output | 1 | Read data word valid |
| rx_data | output | 16 | Read data word |
| tx_data | input | 16 | Next write data word |
| tx_pop | output | 1 | Write word taken this cycle |
| reg_req | output | 1 | Register access request, one cycle per access |
| reg_we | output | 1 | Access is a write |
| reg_addr | output | 7 | Register byte offset |
| reg_wdata | output | 16 | Register write data |
| reg_rdata | input | 16 | Register read data |
| reg_rvalid | input | 1 | Read data valid |
| irq_err | input | 1 | Controller error interrupt |

## Verification
Register effects are due on the clock edge where a request is sampled, so the device model in the bench does its own checks at that edge. These include the gating of commands and buffers on the status it presents, the captured write words, and the gap between a dropped read and its retry. Read words appear on `rx_valid` in the cycle after the model raises `reg_rvalid` and are compared at the falling edge. `req_busy` is due one cycle after the start strobe. `req_err` is checked at the falling edge where `req_done` is high, and the next falling edge must show done and busy low. The lock release after `req_hold` falls is checked after a margin of 30 cycles, which is longer than the read latency of its two accesses.

// File: rtl/sect_seq.sv
module sect_seq #(
  parameter int CNT_W         = 8,
  parameter int BUFS_PER_SECT = 16,
  parameter int WORDS_PER_BUF = 16,
  parameter int TIMEOUT       = 1024
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_start,
  input  logic [1:0]       req_task,
  input  logic [27:0]      req_lba,
  input  logic [CNT_W-1:0] req_count,
  input  logic             req_hold,
  output logic             req_busy,
  output logic             req_done,
  output logic             req_err,
  output logic             rx_valid,
  output logic [15:0]      rx_data,
  input  logic [15:0]      tx_data,
  output logic             tx_pop,
  output logic             reg_req,
  output logic             reg_we,
  output logic [6:0]       reg_addr,
  output logic [15:0]      reg_wdata,
  input  logic [15:0]      reg_rdata,
  input  logic             reg_rvalid,
  input  logic             irq_err
);

  localparam int BUF_W = CNT_W + $clog2(BUFS_PER_SECT) + 1;
  localparam int WI_W  = $clog2(WORDS_PER_BUF);
  localparam int WD_W  = $clog2(TIMEOUT);

  localparam logic [6:0] A_STLO  = 7'h04;
  localparam logic [6:0] A_STHI  = 7'h06;
  localparam logic [6:0] A_LBALO = 7'h10;
  localparam logic [6:0] A_LBAHI = 7'h12;
  localparam logic [6:0] A_CMD   = 7'h14;
  localparam logic [6:0] A_CTRL  = 7'h18;
  localparam logic [6:0] A_DATA  = 7'h40;

  localparam logic [1:0] T_ID = 2'd1;
  localparam logic [1:0] T_RD = 2'd2;
  localparam logic [1:0] T_WR = 2'd3;

  typedef enum logic [4:0] {
    S_IDLE, S_LK_ST, S_LK_CR, S_LK_CW, S_LK_WT, S_RDY_LO, S_RDY_HI,
    S_ADR_LO, S_ADR_HI, S_CMD, S_CR_RD, S_CR_WR, S_BF_LO, S_BF_HI,
    S_XFER, S_DONE, S_RL_RD, S_RL_WR
  } st_t;

  st_t              state;
  logic             pend;
  logic [WD_W-1:0]  wd;
  logic [15:0]      rbuf;
  logic             okbit;
  logic [1:0]       task_q;
  logic [27:0]      lba_q;
  logic [CNT_W-1:0] cnt_q;
  logic [BUF_W-1:0] bufs;
  logic [WI_W-1:0]  widx;
  logic             err_q;
  logic             held;
  logic             is_rd, is_wr, got, wr_task, adv_word, start_ok;
  logic [7:0]       opc;

  assign wr_task  = (task_q == T_WR);
  assign got      = pend && reg_rvalid;
  assign adv_word = (state == S_XFER) && (wr_task || got);
  assign start_ok = req_start && (req_task == T_ID ||
                    (req_task != 2'd0 && req_count != '0));

  always_comb begin
    unique case (state)
      S_LK_ST, S_LK_CR, S_LK_WT, S_RDY_LO, S_RDY_HI,
      S_CR_RD, S_BF_LO, S_BF_HI, S_RL_RD: is_rd = 1'b1;
      S_XFER:                             is_rd = !wr_task;
      default:                            is_rd = 1'b0;
    endcase
    unique case (state)
      S_LK_CW, S_ADR_LO, S_ADR_HI, S_CMD, S_CR_WR, S_RL_WR: is_wr = 1'b1;
      S_XFER:                                               is_wr = wr_task;
      default:                                              is_wr = 1'b0;
    endcase
  end

  always_comb begin
    unique case (task_q)
      T_ID:    opc = 8'h02;
      T_RD:    opc = 8'h03;
      default: opc = 8'h04;
    endcase
    reg_wdata = 16'h0000;
    unique case (state)
      S_LK_ST, S_LK_WT, S_RDY_LO, S_BF_LO: reg_addr = A_STLO;
      S_RDY_HI, S_BF_HI:                  reg_addr = A_STHI;
      S_ADR_LO: begin reg_addr = A_LBALO; reg_wdata = lba_q[15:0]; end
      S_ADR_HI: begin reg_addr = A_LBAHI; reg_wdata = {4'h0, lba_q[27:16]}; end
      S_CMD: begin
        reg_addr  = A_CMD;
        reg_wdata = {opc, (task_q == T_ID) ? 8'h00 : 8'(cnt_q)};
      end
      S_LK_CW: begin reg_addr = A_CTRL; reg_wdata = rbuf | 16'h0002; end
      S_CR_WR: begin reg_addr = A_CTRL; reg_wdata = rbuf | 16'h0080; end
      S_RL_WR: begin reg_addr = A_CTRL; reg_wdata = rbuf & 16'hFFFD; end
      S_XFER:  begin reg_addr = A_DATA; reg_wdata = tx_data; end
      default: reg_addr = A_CTRL;
    endcase
  end

  assign reg_req  = (is_rd && !pend) || is_wr;
  assign reg_we   = is_wr;
  assign tx_pop   = (state == S_XFER) && wr_task;
  assign rx_valid = (state == S_XFER) && !wr_task && got;
  assign rx_data  = reg_rdata;
  assign req_busy = (state != S_IDLE);
  assign req_done = (state == S_DONE);
  assign req_err  = err_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      pend   <= 1'b0;
      wd     <= '0;
      rbuf   <= '0;
      okbit  <= 1'b0;
      task_q <= '0;
      lba_q  <= '0;
      cnt_q  <= '0;
      bufs   <= '0;
      widx   <= '0;
      err_q  <= 1'b0;
      held   <= 1'b0;
    end else begin
      if (state != S_IDLE && irq_err) err_q <= 1'b1;

      if (is_rd && !pend) begin
        pend <= 1'b1;
        wd   <= '0;
      end else if (got) begin
        pend <= 1'b0;
        unique case (state)
          S_LK_ST:  if (reg_rdata[1]) begin held <= 1'b1; state <= S_RDY_LO; end
                    else state <= S_LK_CR;
          S_LK_CR:  begin rbuf <= reg_rdata; state <= S_LK_CW; end
          S_LK_WT:  if (reg_rdata[1]) begin held <= 1'b1; state <= S_RDY_LO; end
          S_RDY_LO: begin okbit <= reg_rdata[8]; state <= S_RDY_HI; end
          S_RDY_HI: if (okbit && !reg_rdata[1])
                      state <= (task_q == T_ID) ? S_CMD : S_ADR_LO;
                    else state <= S_RDY_LO;
          S_CR_RD:  begin rbuf <= reg_rdata; state <= S_CR_WR; end
          S_BF_LO:  begin okbit <= reg_rdata[5]; state <= S_BF_HI; end
          S_BF_HI:  if (okbit && !reg_rdata[1]) begin
                      widx  <= '0;
                      state <= S_XFER;
                    end else state <= S_BF_LO;
          S_RL_RD:  begin rbuf <= reg_rdata; state <= S_RL_WR; end
          default:  ;
        endcase
      end else if (pend) begin
        if (wd == WD_W'(TIMEOUT - 1)) pend <= 1'b0;
        else wd <= wd + 1'b1;
      end

      unique case (state)
        S_LK_CW:  state <= S_LK_WT;
        S_ADR_LO: state <= S_ADR_HI;
        S_ADR_HI: state <= S_CMD;
        S_CMD:    state <= S_CR_RD;
        S_CR_WR:  state <= S_BF_LO;
        S_RL_WR:  begin held <= 1'b0; state <= S_IDLE; end
        S_DONE:   state <= S_IDLE;
        S_IDLE: begin
          if (start_ok) begin
            task_q <= req_task;
            lba_q  <= req_lba;
            cnt_q  <= req_count;
            err_q  <= 1'b0;
            bufs   <= (req_task == T_ID) ? BUF_W'(BUFS_PER_SECT)
                      : BUF_W'(req_count) * BUF_W'(BUFS_PER_SECT);
            state  <= S_LK_ST;
          end else if (held && !req_hold) begin
            state <= S_RL_RD;
          end
        end
        default: ;
      endcase

      if (adv_word) begin
        if (widx == WI_W'(WORDS_PER_BUF - 1)) begin
          widx  <= '0;
          bufs  <= bufs - 1'b1;
          state <= (bufs == BUF_W'(1)) ? S_DONE : S_BF_LO;
        end else begin
          widx <= widx + 1'b1;
        end
      end
    end
  end

  AST_SINGLE_READ: assert property (@(posedge clk) disable iff (!rst_n)
    pend |-> !(reg_req && !reg_we)); // R13
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    req_done |=> !req_done); // R9
  AST_CMD_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_req && reg_we && reg_addr == A_CMD) |-> held); // R2
  AST_DATA_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_req && reg_addr == A_DATA) |-> (bufs != '0)); // R7
  AST_IDLE_NO_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_IDLE) |-> !pend); // R12
  AST_DONE_AFTER_BUF: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(req_done) |-> $past(state == S_XFER)); // R9

endmodule

// File: tb/sect_seq_bench.sv
module sect_seq_bench;
  localparam int CLK_PERIOD = 10;
  localparam int TMO = 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_start = 1'b0;
  logic [1:0] req_task = 2'd0;
  logic [27:0] req_lba = '0;
  logic [7:0] req_count = '0;
  logic req_hold = 1'b1;
  logic irq_err = 1'b0;
  logic [15:0] tx_data;
  logic req_busy, req_done, req_err, rx_valid, tx_pop;
  logic [15:0] rx_data;
  logic reg_req, reg_we, reg_rvalid;
  logic [6:0] reg_addr;
  logic [15:0] reg_wdata, reg_rdata;

  sect_seq #(.CNT_W(8), .BUFS_PER_SECT(16), .WORDS_PER_BUF(16), .TIMEOUT(TMO)) u_sect_seq (
    .clk(clk), .rst_n(rst_n), .req_start(req_start), .req_task(req_task),
    .req_lba(req_lba), .req_count(req_count), .req_hold(req_hold),
    .req_busy(req_busy), .req_done(req_done), .req_err(req_err),
    .rx_valid(rx_valid), .rx_data(rx_data), .tx_data(tx_data), .tx_pop(tx_pop),
    .reg_req(reg_req), .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .reg_rvalid(reg_rvalid), .irq_err(irq_err));

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [15:0] rxw(input int n);
    return 16'hA5C3 ^ 16'(n * 263);
  endfunction
  function automatic logic [15:0] txw(input int n);
    return 16'h3C11 + 16'(n * 77);
  endfunction

  int n_pass = 0, n_fail = 0;
  task automatic chk(input bit ok, input string r, input longint act, input longint exp);
    if (ok) n_pass++;
    else begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
    end
  endtask

  // device model configuration (written by the bench tasks only)
  logic load = 1'b0;
  logic [15:0] cfg_ctrl = '0;
  logic cfg_lock = 1'b0, cfg_drop = 1'b0;
  int cfg_rdy = 0, cfg_busy = 0;

  // device model state (written by the model only)
  int cyc = 0, rdy_cnt = 0, busy_cnt = 0, lock_dly = 0, buf_dly = 0, wcnt = 0, resp_cnt = 0;
  int rd_seq = 0, tx_seq = 0, t_drop = 0, wd_gap = 0;
  int n_cmd = 0, n_ctrl = 0, n_adr = 0, n_data = 0, n_acc = 0;
  int cmd_viol = 0, data_viol = 0, rd_viol = 0, tx_bad = 0;
  logic lock_gnt = 1'b0, bufrdy = 1'b0, data_on = 1'b0, drop_arm = 1'b0, wd_wait = 1'b0;
  logic [15:0] ctrl = '0, lba_lo = '0, lba_hi = '0, last_cmd = '0, resp_data = '0;
  logic [15:0] st_lo, st_hi;
  initial begin reg_rvalid = 1'b0; reg_rdata = '0; tx_data = txw(0); end

  assign st_lo = {7'b0, rdy_cnt == 0, 2'b0, bufrdy, 3'b0, lock_gnt, 1'b0};
  assign st_hi = {14'b0, busy_cnt != 0, 1'b0};

  always @(posedge clk) begin
    cyc <= cyc + 1;
    reg_rvalid <= 1'b0;
    if (resp_cnt != 0) begin
      resp_cnt <= resp_cnt - 1;
      if (resp_cnt == 1) begin reg_rvalid <= 1'b1; reg_rdata <= resp_data; end
    end
    if (rdy_cnt != 0) rdy_cnt <= rdy_cnt - 1;
    if (busy_cnt != 0) busy_cnt <= busy_cnt - 1;
    if (lock_dly != 0) begin
      lock_dly <= lock_dly - 1;
      if (lock_dly == 1) lock_gnt <= 1'b1;
    end
    if (data_on && !bufrdy) begin
      if (buf_dly > 1) buf_dly <= buf_dly - 1;
      else begin bufrdy <= 1'b1; busy_cnt <= int'($urandom_range(0, 5)); end
    end
    if (load) begin
      ctrl <= cfg_ctrl; lock_gnt <= cfg_lock; rdy_cnt <= cfg_rdy; busy_cnt <= cfg_busy;
      drop_arm <= cfg_drop; data_on <= 1'b0; bufrdy <= 1'b0; wcnt <= 0; lock_dly <= 0;
    end
    if (rst_n && reg_req) begin
      n_acc <= n_acc + 1;
      if (reg_addr == 7'h40) begin
        n_data <= n_data + 1;
        if (!bufrdy || busy_cnt != 0) data_viol <= data_viol + 1;
        if (wcnt == 15) begin
          wcnt <= 0; bufrdy <= 1'b0; buf_dly <= int'($urandom_range(1, 8));
        end else wcnt <= wcnt + 1;
      end
      if (!reg_we) begin
        if (resp_cnt != 0) rd_viol <= rd_viol + 1;
        if (drop_arm) begin
          drop_arm <= 1'b0; t_drop <= cyc; wd_wait <= 1'b1;
        end else begin
          if (wd_wait) begin wd_gap <= cyc - t_drop; wd_wait <= 1'b0; end
          resp_cnt <= int'($urandom_range(1, 3));
          case (reg_addr)
            7'h04: resp_data <= st_lo;
            7'h06: resp_data <= st_hi;
            7'h18: resp_data <= ctrl;
            7'h40: begin resp_data <= rxw(rd_seq); rd_seq <= rd_seq + 1; end
            default: resp_data <= 16'h0000;
          endcase
        end
      end else begin
        case (reg_addr)
          7'h18: begin
            ctrl <= reg_wdata; n_ctrl <= n_ctrl + 1;
            if (reg_wdata[1] && !lock_gnt && lock_dly == 0) lock_dly <= int'($urandom_range(1, 6));
            if (!reg_wdata[1]) begin lock_gnt <= 1'b0; lock_dly <= 0; end
          end
          7'h10: begin lba_lo <= reg_wdata; n_adr <= n_adr + 1; end
          7'h12: begin lba_hi <= reg_wdata; n_adr <= n_adr + 1; end
          7'h14: begin
            last_cmd <= reg_wdata; n_cmd <= n_cmd + 1;
            if (!(rdy_cnt == 0 && busy_cnt == 0 && lock_gnt)) cmd_viol <= cmd_viol + 1;
            data_on <= 1'b1; bufrdy <= 1'b0; buf_dly <= int'($urandom_range(1, 8));
          end
          7'h40: begin
            if (reg_wdata != txw(tx_seq) || !tx_pop) tx_bad <= tx_bad + 1;
            tx_seq <= tx_seq + 1; tx_data <= txw(tx_seq + 1);
          end
          default: ;
        endcase
      end
    end
  end

  int rx_seen = 0, rx_bad = 0;
  always @(negedge clk) if (rx_valid) begin
    if (rx_data != rxw(rx_seen)) rx_bad <= rx_bad + 1;
    rx_seen <= rx_seen + 1;
  end

  logic [15:0] last_base = '0;

  task automatic run_op(input logic [1:0] t, input logic [27:0] lba, input logic [7:0] cnt,
                        input bit lock_pre, input bit inj, input bit drop, input bit extra);
    logic [15:0] base;
    int s_cmd, s_ctrl, s_adr, s_data, s_cv, s_dv, s_rv, s_tb, s_rx, s_rb, words, n;
    base = 16'($urandom) & 16'hFF7D;
    last_base = base;
    cfg_ctrl = lock_pre ? (base | 16'h0002) : base;
    cfg_lock = lock_pre; cfg_rdy = int'($urandom_range(0, 12));
    cfg_busy = int'($urandom_range(0, 6)); cfg_drop = drop;
    @(negedge clk); load = 1'b1;
    @(negedge clk); load = 1'b0;
    s_cmd = n_cmd; s_ctrl = n_ctrl; s_adr = n_adr; s_data = n_data; s_cv = cmd_viol;
    s_dv = data_viol; s_rv = rd_viol; s_tb = tx_bad; s_rx = rx_seen; s_rb = rx_bad;
    words = (t == 2'd1) ? 256 : int'(cnt) * 256;
    req_task = t; req_lba = lba; req_count = cnt; req_start = 1'b1;
    @(negedge clk); req_start = 1'b0;
    chk(req_busy == 1'b1, "R9 busy after start", req_busy, 1);
    n = 0;
    while (!req_done && n < 30000) begin
      @(negedge clk); n++;
      if (n == 25) irq_err = inj;
      if (n == 26) irq_err = 1'b0;
      if (n == 40 && extra) begin req_task = 2'd1; req_start = 1'b1; end
      if (n == 41) req_start = 1'b0;
    end
    chk(req_done == 1'b1, "R9 done reached", req_done, 1);
    chk(req_err == inj, "R10 error with done", req_err, inj);
    @(negedge clk);
    chk(!req_done && !req_busy, "R9 done one cycle then idle", {req_done, req_busy}, 0);
    chk(last_cmd == {(t == 2'd1) ? 8'h02 : (t == 2'd2) ? 8'h03 : 8'h04,
                     (t == 2'd1) ? 8'h00 : cnt}, "R4 command word", last_cmd,
        {(t == 2'd1) ? 8'h02 : (t == 2'd2) ? 8'h03 : 8'h04, (t == 2'd1) ? 8'h00 : cnt});
    chk(n_cmd - s_cmd == 1, "R9 one command per op", n_cmd - s_cmd, 1);
    if (t == 2'd1) chk(n_adr == s_adr, "R5 identify writes no address", n_adr - s_adr, 0);
    else begin
      chk(n_adr - s_adr == 2, "R5 address writes", n_adr - s_adr, 2);
      chk(lba_lo == lba[15:0] && lba_hi == {4'h0, lba[27:16]}, "R5 address halves",
          {lba_hi, lba_lo}, {4'h0, lba[27:16], lba[15:0]});
    end
    chk(ctrl == (base | 16'h0082), "R6 config reset bit preserved others", ctrl, base | 16'h0082);
    chk(n_ctrl - s_ctrl == (lock_pre ? 1 : 2), "R2 lock request writes", n_ctrl - s_ctrl,
        lock_pre ? 1 : 2);
    chk(cmd_viol == s_cv, "R3 command gated on ready", cmd_viol - s_cv, 0);
    chk(data_viol == s_dv, "R7 buffer gated on status", data_viol - s_dv, 0);
    chk(n_data - s_data == words, "R7 data access count", n_data - s_data, words);
    if (t == 2'd3) chk(tx_bad == s_tb, "R8 write words", tx_bad - s_tb, 0);
    else begin
      chk(rx_seen - s_rx == words, "R8 read word count", rx_seen - s_rx, words);
      chk(rx_bad == s_rb, "R8 read word order", rx_bad - s_rb, 0);
    end
    chk(rd_viol == s_rv, "R13 single outstanding read", rd_viol - s_rv, 0);
    if (drop) chk(wd_gap == TMO + 1, "R12 retry gap", wd_gap, TMO + 1);
  endtask

  initial begin
    int s_acc;
    void'($urandom(32'h51C7));
    repeat (3) @(negedge clk);
    chk(!reg_req && !req_done && !req_busy, "R1 reset outputs", {reg_req, req_done, req_busy}, 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk(!reg_req && !req_busy && n_acc == 0, "R1 quiet after reset", n_acc, 0);

    s_acc = n_acc;
    req_task = 2'd0; req_start = 1'b1; @(negedge clk);
    req_task = 2'd2; req_count = 8'd0; @(negedge clk); req_start = 1'b0;
    repeat (10) @(negedge clk);
    chk(!req_busy && n_acc == s_acc, "R9 invalid starts ignored", n_acc - s_acc, 0);

    run_op(2'd1, 28'h0000000, 8'd0, 1'b0, 1'b0, 1'b0, 1'b0);
    run_op(2'd2, 28'hABCDEF1, 8'd2, 1'b1, 1'b0, 1'b0, 1'b0);
    run_op(2'd3, 28'h0123456, 8'd1, 1'b0, 1'b1, 1'b0, 1'b0);
    run_op(2'd2, 28'hFFFFFFF, 8'd1, 1'b0, 1'b0, 1'b1, 1'b0);
    run_op(2'd3, 28'h8000001, 8'd2, 1'b1, 1'b0, 1'b0, 1'b1);

    req_hold = 1'b0;
    repeat (30) @(negedge clk);
    chk(ctrl == ((last_base | 16'h0082) & 16'hFFFD), "R11 lock released", ctrl,
        (last_base | 16'h0082) & 16'hFFFD);
    chk(!lock_gnt && !req_busy, "R11 idle after release", {lock_gnt, req_busy}, 0);
    req_hold = 1'b1;
    run_op(2'd2, 28'h0000100, 8'd1, 1'b0, 1'b0, 1'b0, 1'b0);

    for (int i = 0; i < 6; i++) begin
      run_op(2'(int'($urandom_range(1, 3))), 28'($urandom), 8'(int'($urandom_range(1, 3))),
             1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
             ($urandom_range(0, 3) == 0), 1'b0);
    end

    $display("%0d/%0d checks passed", n_pass, n_pass + n_fail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_fail++;
    $display("FAIL R9 watchdog expired actual=running expected=finished");
    $display("%0d/%0d checks passed", n_pass, n_pass + n_fail);
    $finish;
  end
endmodule